// File: doc/BRIEF.md
# Interleaved Multiphase Input Synchronizer

This block brings one asynchronous bit into a fast clock domain. A plain chain of flops gives each stage only one clock period to settle. This block instead runs NUM_PHASES parallel capture lanes. Each lane is clock-enabled once every NUM_PHASES cycles, so every stage has NUM_PHASES periods to resolve. The lanes' enables fall on consecutive cycles, so together they still sample the input on every clock edge.

A free-running phase counter picks which lane captures in a given cycle. The same counter also picks which lane's settled value is handed to the output. The selector sits after the per-lane registers, so its delay never eats into resolving time. The output follows the input with a fixed latency of NUM_PHASES+1 cycles whatever the phase of an input change. After reset the output is forced low until every lane has finished a full capture and hand-over.

Top module: `interleaved_sync`

## Requirements
- R1: While rst_n (active low, synchronous) is sampled low, sync_out is 0, and it is still 0 after the first clock edge that follows the release.
- R2: Number the clock edges after reset release 0, 1, 2, ... From edge 2*NUM_PHASES onward, sync_out after edge e equals async_in as sampled at edge e-(NUM_PHASES+1). No sample is dropped.
- R3: A one-cycle pulse on async_in appears on sync_out exactly NUM_PHASES+1 cycles later, one cycle wide, whichever phase it lands on.
- R4: After edges 0 to 2*NUM_PHASES-1 following release, sync_out is 0 even if async_in is held at 1.
- R5: A reset asserted in mid-run discards every captured sample and restarts the warm-up of R4.
- R6: The phase counter is 0 at the first edge after release and steps by one, modulo NUM_PHASES, each cycle. Lane k is enabled exactly when the counter equals k, so exactly one lane is enabled per cycle.
- R7: A lane's capture and hold registers change only on the edge at which that lane is enabled. The lanes therefore never disturb one another: a pattern that toggles every cycle is reproduced intact.
- R8: With NUM_PHASES set to 2, the block meets R2 and R4 with a latency of 3 cycles and a warm-up of 4 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| async_in | input | 1 | Asynchronous input bit |
| sync_out | output | 1 | Synchronized bit, delayed NUM_PHASES+1 cycles |

## Verification
On every edge, one lane's hold stage takes the value that its capture stage took NUM_PHASES cycles earlier, while the same capture stage takes a fresh sample. In that same cycle the selector must already be reading a different, just-settled lane. Driving async_in so that it toggles every cycle, and injecting single-cycle pulses at each of the phases in turn, puts a new sample and a hand-over into the same lane at the same edge. The bench's history model then finds any sample that was lost, duplicated or taken from the wrong lane. A second pair of functions meets at the end of warm-up: the first valid value leaves the gate on the very edge where the gate opens. Holding the input high through warm-up, then checking the exact edge where the output first rises, judges that boundary for both phase counts.

// File: rtl/isync_pkg.sv
// Package: shared helpers for the interleaved synchronizer.
// Assumes a phase count of at least 2.
package isync_pkg;

    // Width of a counter that holds values 0 .. n-1.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/isync_phase_gen.sv
// Module: isync_phase_gen
// A free-running phase counter that wraps at NUM_PHASES-1. It makes a
// one-hot lane enable and the index of the lane whose hold stage was
// written on the previous edge.
// Assumes: NUM_PHASES >= 2 and a synchronous active-low reset.
module isync_phase_gen
    import isync_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    output logic [idx_width(NUM_PHASES)-1:0]     phase_q,
    output logic [NUM_PHASES-1:0]                lane_en,
    output logic [idx_width(NUM_PHASES)-1:0]     sel_idx
);
    localparam int unsigned PW = idx_width(NUM_PHASES);
    localparam logic [PW-1:0] LAST = PW'(NUM_PHASES - 1);

    // Advance the phase by one per cycle and wrap after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // Decode one enable per lane.
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_en
        assign lane_en[k] = (phase_q == PW'(k));
    end

    // The lane that was written last is the one before the current phase.
    always_comb begin
        if (phase_q == '0)
            sel_idx = LAST;
        else
            sel_idx = phase_q - 1'b1;
    end

endmodule

// File: rtl/isync_lane.sv
// Module: isync_lane
// One capture lane. A first flop samples the asynchronous input on the
// lane's enable. A second flop takes that value at the next enable,
// NUM_PHASES cycles later, so the first flop gets NUM_PHASES periods to
// settle. The second flop is this lane's own output register.
// Assumes: en is high for one cycle out of every NUM_PHASES.
module isync_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic cap_q,
    output logic hold_q
);
    // Capture stage: sample the raw input on this lane's slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= 1'b0;
        else if (en)
            cap_q <= din;
    end

    // Hold stage: pass the settled capture on at the following slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (en)
            hold_q <= cap_q;
    end

endmodule

// File: rtl/isync_out_sel.sv
// Module: isync_out_sel
// Picks the freshest lane hold value and registers it onto the output.
// A warm-up counter keeps the output at 0 until every lane has finished
// one capture and one hand-over, which takes 2*NUM_PHASES edges.
// Assumes: sel_idx always points at a lane below NUM_PHASES.
module isync_out_sel
    import isync_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PHASES-1:0]             hold_vec,
    input  logic [idx_width(NUM_PHASES)-1:0]  sel_idx,
    output logic                              sync_out
);
    localparam int unsigned WARM_EDGES = 2 * NUM_PHASES;
    localparam int unsigned CW = $clog2(WARM_EDGES + 1);
    localparam logic [CW-1:0] WARM_DONE = CW'(WARM_EDGES);

    logic [CW-1:0] warm_q;
    logic          primed;

    assign primed = (warm_q == WARM_DONE);

    // Count edges since reset and stop once warm-up is over.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (!primed)
            warm_q <= warm_q + 1'b1;
    end

    // Register the selected lane, or 0 while still warming up.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_out <= 1'b0;
        else
            sync_out <= primed ? hold_vec[sel_idx] : 1'b0;
    end

endmodule

// File: rtl/interleaved_sync.sv
// Module: interleaved_sync (top)
// Synchronizes one asynchronous bit through NUM_PHASES phase-staggered
// two-stage lanes. The fixed latency is NUM_PHASES+1 cycles.
// Assumes: NUM_PHASES >= 2 and rst_n synchronous to clk.
module interleaved_sync
    import isync_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int unsigned PW = idx_width(NUM_PHASES);

    logic [PW-1:0]         phase_q;
    logic [PW-1:0]         sel_idx;
    logic [NUM_PHASES-1:0] lane_en;
    logic [NUM_PHASES-1:0] lane_cap;
    logic [NUM_PHASES-1:0] lane_hold;

    isync_phase_gen #(.NUM_PHASES(NUM_PHASES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q),
        .lane_en (lane_en),
        .sel_idx (sel_idx)
    );

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_lane
        isync_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (lane_en[k]),
            .din    (async_in),
            .cap_q  (lane_cap[k]),
            .hold_q (lane_hold[k])
        );
    end

    isync_out_sel #(.NUM_PHASES(NUM_PHASES)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_vec (lane_hold),
        .sel_idx  (sel_idx),
        .sync_out (sync_out)
    );

endmodule

// File: rtl/interleaved_sync_chk.sv
// Module: interleaved_sync_chk
// Property checker bound into every interleaved_sync instance. It keeps
// its own edge counter and input history, so the latency window needs no
// deep $past.
module interleaved_sync_chk
    import isync_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              async_in,
    input logic                              sync_out,
    input logic [idx_width(NUM_PHASES)-1:0]  phase_q,
    input logic [NUM_PHASES-1:0]             lane_en,
    input logic [NUM_PHASES-1:0]             lane_cap,
    input logic [NUM_PHASES-1:0]             lane_hold
);
    localparam int unsigned PW = idx_width(NUM_PHASES);
    localparam int unsigned LIM = 2 * NUM_PHASES + 1;
    localparam int unsigned CW = $clog2(LIM + 1);

    logic [CW-1:0]         edges_q;
    logic [NUM_PHASES+1:0] hist_q;

    // Edges since release, saturating once the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            edges_q <= '0;
        else if (edges_q != CW'(LIM))
            edges_q <= edges_q + 1'b1;
    end

    // Input history: bit i holds the input sampled i edges ago.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else
            hist_q <= {hist_q[NUM_PHASES:0], async_in};
    end

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(NUM_PHASES - 1)) ? '0 : p + 1'b1;
    endfunction

    // R6: the phase starts at 0 after release.
    p_phase_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == '0) |-> (phase_q == '0));

    // R6: the phase advances by one per cycle, modulo NUM_PHASES.
    p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_q == step($past(phase_q))));

    // R6: exactly one lane is enabled in every cycle.
    p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_en) == 1);

    // R4: the output stays low during warm-up.
    p_warm_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q < CW'(LIM)) |-> (sync_out == 1'b0));

    // R2: the output is the input from NUM_PHASES+1 edges back.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == CW'(LIM)) |-> (sync_out == hist_q[NUM_PHASES+1]));

    // R7: a lane's registers move only on that lane's own slot.
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_lane_chk
        p_cap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[k] |=> $stable(lane_cap[k]));
        p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[k] |=> $stable(lane_hold[k]));
    end

endmodule

bind interleaved_sync interleaved_sync_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (async_in),
    .sync_out  (sync_out),
    .phase_q   (phase_q),
    .lane_en   (lane_en),
    .lane_cap  (lane_cap),
    .lane_hold (lane_hold)
);

// File: tb/interleaved_sync_tb.sv
// Bench: drives two instances (4 phases and 2 phases) from one input and
// checks both against a history model of the input.
module interleaved_sync_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic q4, q2;

    int checks = 0;
    int errors = 0;
    int e = 0;
    logic hist [0:1023];

    always #10 clk = ~clk;

    interleaved_sync #(.NUM_PHASES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .async_in(din), .sync_out(q4));

    interleaved_sync #(.NUM_PHASES(2)) u_dut_n2 (
        .clk(clk), .rst_n(rst_n), .async_in(din), .sync_out(q2));

    // Expected output after edge idx for a given phase count.
    function automatic logic expect_out(input int n, input int idx);
        if (idx < 2 * n) return 1'b0;
        return hist[idx - n - 1];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge %0d actual %b expected %b", tag, e, act, exp);
        end
    endtask

    // One cycle: drive v, let the edge happen, check both outputs.
    task automatic tick(input logic v, input string tag);
        din = v;
        @(posedge clk);
        hist[e] = v;
        #2;
        check(tag, q4, expect_out(4, e));
        check("R8", q2, expect_out(2, e));
        e++;
        @(negedge clk);
    endtask

    // Hold reset for n cycles, checking that both outputs are 0.
    task automatic hold_reset(input int n, input string tag);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            check(tag, q4, 1'b0);
            check(tag, q2, 1'b0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        e = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        din = 1'b1;
        hold_reset(3, "R1");
        // R1 and R4: input high from the first edge, output gated low.
        for (int i = 0; i < 8; i++) tick(1'b1, i == 0 ? "R1" : "R4");
        // R2: random input past the warm-up.
        for (int i = 0; i < 60; i++) tick(1'($urandom_range(0, 1)), "R2");
        // R3 and R6: single pulses landing on each phase slot.
        for (int i = 0; i < 10; i++) tick(1'b0, "R3");
        for (int k = 0; k < 4; k++) begin
            while ((e % 4) != k) tick(1'b0, "R6");
            tick(1'b1, "R3");
            for (int i = 0; i < 8; i++) tick(1'b0, "R3");
        end
        // R7: a toggle on every cycle must survive intact.
        for (int i = 0; i < 24; i++) tick(1'(e % 2), "R7");
        // R5: reset in mid-run with the input high, then a fresh warm-up.
        din = 1'b1;
        hold_reset(2, "R5");
        for (int i = 0; i < 8; i++) tick(1'b1, "R5");
        for (int i = 0; i < 60; i++) tick(1'($urandom_range(0, 1)), "R2");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule